// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Resolver

This block turns one inter-processor interrupt command into the set of processors that must receive it, for a system of up to `NUM_CPU` processors. Each command carries a destination byte, a physical/logical mode bit, a two-bit shorthand, a delivery mode and the index of the sending processor. Per processor, the block also sees an 8-bit physical ID, an 8-bit logical ID, a destination format code, a present flag and an enable flag.

For most delivery modes every processor that matches is a target, so the output can have many bits set. Lowest-priority delivery works differently: one target is picked from the matching, enabled processors. The pick is round-robin, and its pointer persists from one request to the next. A command is presented with a one-cycle strobe. The target vector follows one cycle later with its own strobe.

Top module: `ipi_dest_resolver`

## Requirements
- R1: The shorthand selects the match rule. 0 uses the destination field. 1 targets only the sender. 2 targets every processor. 3 targets every processor except the sender.
- R2: With shorthand 0 and the mode bit at 0 (physical), a processor matches when the destination is 0xFF or equals its physical ID.
- R3: With shorthand 0 and the mode bit at 1 (logical), a processor whose format code is 2'b00 (flat) matches when its logical ID AND the destination is nonzero.
- R4: In logical mode, a processor whose format code is 2'b01 (cluster) matches when the upper nibbles of its logical ID and the destination are equal and the AND of their lower nibbles is nonzero.
- R5: In logical mode, a processor whose format code is 2'b10 or 2'b11 matches nothing.
- R6: Delivery mode 3'd1 is lowest priority. The search starts at the index after the round-robin pointer and wraps around. It stops at the first matching processor that is also enabled, and only that processor is targeted.
- R7: In lowest-priority delivery, the pointer moves to the chosen index. When no candidate is found, the pointer stays where it was and the target vector is all zero.
- R8: Any delivery mode other than 3'd1 targets every matching processor, and the enable flags have no effect.
- R9: A processor whose present flag is low is never targeted under any shorthand or mode, including shorthand 2.
- R10: The result strobe is high exactly one cycle after a command strobe. The target vector is zero whenever the result strobe is low. Reset clears the round-robin pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| dest_i | input | 8 | Destination byte |
| dest_logical_i | input | 1 | 0 = physical, 1 = logical addressing |
| shorthand_i | input | 2 | Shorthand code |
| dlv_mode_i | input | 3 | Delivery mode (3'd1 = lowest priority) |
| sender_i | input | IDX_W | Index of the sending processor |
| cpu_present_i | input | NUM_CPU | Processor exists |
| cpu_enabled_i | input | NUM_CPU | Processor accepts lowest-priority interrupts |
| apic_id_i | input | NUM_CPU*8 | Packed physical IDs, processor i in bits [8i+7:8i] |
| logical_id_i | input | NUM_CPU*8 | Packed logical IDs |
| dest_fmt_i | input | NUM_CPU*2 | Packed destination format codes |
| res_valid_o | output | 1 | Result strobe |
| targets_o | output | NUM_CPU | Target processor vector |

## Verification
Every result is due exactly one clock after its command strobe. The bench drives each command on a falling edge, releases the strobe on the next falling edge and compares the target vector there, half a cycle after the capturing rising edge. The reference model advances its round-robin pointer only when it predicts a lowest-priority result, so pointer state is checked implicitly across consecutive commands. Idle cycles are sampled the same way to confirm that the strobe and the vector both stay at zero.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned ID_W = 8;
  localparam int unsigned NIB_W = ID_W / 2;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [1:0] FMT_FLAT    = 2'b00;
  localparam logic [1:0] FMT_CLUSTER = 2'b01;
  localparam logic [2:0] DLV_LOWEST  = 3'd1;
  localparam logic [ID_W-1:0] DEST_BCAST = '1;
endpackage

// File: rtl/ipi_cpu_match.sv
module ipi_cpu_match
  import ipi_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned IDX   = 0
) (
  input  logic [ID_W-1:0]  dest_i,
  input  logic             dest_logical_i,
  input  logic [1:0]       shorthand_i,
  input  logic [IDX_W-1:0] sender_i,
  input  logic             present_i,
  input  logic [ID_W-1:0]  apic_id_i,
  input  logic [ID_W-1:0]  logical_id_i,
  input  logic [1:0]       fmt_i,
  output logic             hit_o
);
  logic is_self, phys_hit, flat_hit, clus_hit, log_hit, rule_hit;

  assign is_self  = (sender_i == IDX_W'(IDX));
  assign phys_hit = (dest_i == DEST_BCAST) || (dest_i == apic_id_i);
  assign flat_hit = |(logical_id_i & dest_i);
  assign clus_hit = (logical_id_i[ID_W-1:NIB_W] == dest_i[ID_W-1:NIB_W]) &&
                    (|(logical_id_i[NIB_W-1:0] & dest_i[NIB_W-1:0]));

  always_comb begin
    unique case (fmt_i)
      FMT_FLAT:    log_hit = flat_hit;
      FMT_CLUSTER: log_hit = clus_hit;
      default:     log_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (shorthand_e'(shorthand_i))
      SH_DEST:   rule_hit = dest_logical_i ? log_hit : phys_hit;
      SH_SELF:   rule_hit = is_self;
      SH_ALL:    rule_hit = 1'b1;
      SH_OTHERS: rule_hit = !is_self;
      default:   rule_hit = 1'b0;
    endcase
  end

  assign hit_o = present_i && rule_hit;
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               advance_i,
  input  logic [NUM_CPU-1:0] cand_i,
  output logic [NUM_CPU-1:0] grant_o
);
  logic [IDX_W-1:0] ptr_q, pick_idx;
  logic             found;

  // search ptr+1 .. ptr (wrapping); the old holder is tried last
  always_comb begin
    found    = 1'b0;
    pick_idx = ptr_q;
    for (int k = 1; k <= int'(NUM_CPU); k++) begin
      int unsigned j;
      j = (int'(ptr_q) + k) % NUM_CPU;
      if (!found && cand_i[j]) begin
        found    = 1'b1;
        pick_idx = IDX_W'(j);
      end
    end
    grant_o = '0;
    if (found) grant_o[pick_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (advance_i) ptr_q <= pick_idx;
  end
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic [7:0]              dest_i,
  input  logic                    dest_logical_i,
  input  logic [1:0]              shorthand_i,
  input  logic [2:0]              dlv_mode_i,
  input  logic [IDX_W-1:0]        sender_i,
  input  logic [NUM_CPU-1:0]      cpu_present_i,
  input  logic [NUM_CPU-1:0]      cpu_enabled_i,
  input  logic [NUM_CPU*8-1:0]    apic_id_i,
  input  logic [NUM_CPU*8-1:0]    logical_id_i,
  input  logic [NUM_CPU*2-1:0]    dest_fmt_i,
  output logic                    res_valid_o,
  output logic [NUM_CPU-1:0]      targets_o
);
  logic [NUM_CPU-1:0] match_vec, grant, nxt_targets;
  logic               is_lowest;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    ipi_cpu_match #(.IDX_W(IDX_W), .IDX(g)) u_match (
      .dest_i         (dest_i),
      .dest_logical_i (dest_logical_i),
      .shorthand_i    (shorthand_i),
      .sender_i       (sender_i),
      .present_i      (cpu_present_i[g]),
      .apic_id_i      (apic_id_i[g*ID_W +: ID_W]),
      .logical_id_i   (logical_id_i[g*ID_W +: ID_W]),
      .fmt_i          (dest_fmt_i[g*2 +: 2]),
      .hit_o          (match_vec[g])
    );
  end

  assign is_lowest = (dlv_mode_i == DLV_LOWEST);

  ipi_rr_pick #(.NUM_CPU(NUM_CPU)) u_rr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (cmd_valid_i && is_lowest),
    .cand_i    (match_vec & cpu_enabled_i),
    .grant_o   (grant)
  );

  assign nxt_targets = is_lowest ? grant : match_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      targets_o   <= '0;
    end else begin
      res_valid_o <= cmd_valid_i;
      targets_o   <= cmd_valid_i ? nxt_targets : '0;
    end
  end
endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk
  import ipi_pkg::*;
#(
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_i,
  input logic [1:0]         shorthand_i,
  input logic [2:0]         dlv_mode_i,
  input logic [IDX_W-1:0]   sender_i,
  input logic [NUM_CPU-1:0] cpu_present_i,
  input logic               res_valid_o,
  input logic [NUM_CPU-1:0] targets_o
);
  AST_RES_FOLLOWS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> res_valid_o); // R10
  AST_NO_SPURIOUS_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !res_valid_o); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (targets_o == '0)); // R10
  AST_LOWEST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && dlv_mode_i == DLV_LOWEST) |=> $onehot0(targets_o)); // R6
  AST_ABSENT_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> ((targets_o & ~$past(cpu_present_i)) == '0)); // R9
  AST_SELF_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && shorthand_i == 2'd1) |=>
      ((targets_o & ~(NUM_CPU'(1) << $past(sender_i))) == '0)); // R1
endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .shorthand_i   (shorthand_i),
  .dlv_mode_i    (dlv_mode_i),
  .sender_i      (sender_i),
  .cpu_present_i (cpu_present_i),
  .res_valid_o   (res_valid_o),
  .targets_o     (targets_o)
);

// File: tb/ipi_dest_resolver_bench.sv
`timescale 1ns/1ps
module ipi_dest_resolver_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [7:0]   dest = '0;
  logic         dest_logical = 1'b0;
  logic [1:0]   shorthand = '0;
  logic [2:0]   dlv_mode = '0;
  logic [2:0]   sender = '0;
  logic [N-1:0] present = '1;
  logic [N-1:0] enabled = '1;
  logic [7:0]   apic_id [N];
  logic [7:0]   log_id  [N];
  logic [1:0]   fmt     [N];
  logic [N*8-1:0] apic_id_p, log_id_p;
  logic [N*2-1:0] fmt_p;
  logic         res_valid;
  logic [N-1:0] targets;

  int total = 0;
  int bad = 0;
  int rr_ptr = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      apic_id_p[i*8 +: 8] = apic_id[i];
      log_id_p[i*8 +: 8]  = log_id[i];
      fmt_p[i*2 +: 2]     = fmt[i];
    end
  end

  ipi_dest_resolver #(.NUM_CPU(N)) u_ipi_dest_resolver (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .dest_i(dest),
    .dest_logical_i(dest_logical), .shorthand_i(shorthand), .dlv_mode_i(dlv_mode),
    .sender_i(sender), .cpu_present_i(present), .cpu_enabled_i(enabled),
    .apic_id_i(apic_id_p), .logical_id_i(log_id_p), .dest_fmt_i(fmt_p),
    .res_valid_o(res_valid), .targets_o(targets)
  );

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_hit(int i);
    bit h;
    if (!present[i]) return 0;
    case (shorthand)
      2'd1: h = (i == int'(sender));
      2'd2: h = 1;
      2'd3: h = (i != int'(sender));
      default:
        if (!dest_logical) h = (dest == 8'hFF) || (dest == apic_id[i]);
        else if (fmt[i] == 2'b00) h = (log_id[i] & dest) != 0;
        else if (fmt[i] == 2'b01)
          h = (log_id[i][7:4] == dest[7:4]) && ((log_id[i][3:0] & dest[3:0]) != 0);
        else h = 0;
    endcase
    return h;
  endfunction

  function automatic logic [N-1:0] ref_targets();
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) m[i] = ref_hit(i);
    if (dlv_mode != 3'd1) return m;
    for (int k = 1; k <= N; k++) begin
      int j = (rr_ptr + k) % N;
      if (m[j] && enabled[j]) begin
        rr_ptr = j;
        return N'(1) << j;
      end
    end
    return '0;
  endfunction

  task automatic send(string req, logic [7:0] d, logic lg, logic [1:0] sh,
                      logic [2:0] md, logic [2:0] snd);
    logic [N-1:0] exp;
    @(negedge clk);
    dest = d; dest_logical = lg; shorthand = sh; dlv_mode = md; sender = snd;
    cmd_valid = 1'b1;
    exp = ref_targets();
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " R10 strobe"}, N'(res_valid), N'(1));
    check(req, targets, exp);
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R10 idle", {res_valid, targets[N-2:0]}, '0);
    check("R10 idle targets", targets, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      apic_id[i] = 8'h10 + 8'(i);
      log_id[i]  = 8'(1 << i);
      fmt[i]     = 2'b00;
    end
    repeat (3) @(negedge clk);
    check("R10 reset valid", N'(res_valid), '0);
    check("R10 reset targets", targets, '0);
    rst_n = 1'b1;
    idle_check();

    send("R2 physical id", 8'h13, 0, 0, 0, 0);
    check("R2 literal", targets, 8'h08);
    present[5] = 1'b0;
    send("R2 R9 broadcast", 8'hFF, 0, 0, 0, 0);
    check("R9 literal", targets, 8'hDF);
    send("R1 R9 all incl", 8'h00, 0, 2, 0, 0);
    present[5] = 1'b1;
    send("R3 flat", 8'h0A, 1, 0, 0, 0);
    check("R3 literal", targets, 8'h0A);
    for (int i = 0; i < N; i++) begin
      fmt[i] = 2'b01;
      log_id[i] = {4'(i / 4), 4'(1 << (i % 4))};
    end
    send("R4 cluster1", 8'h13, 1, 0, 0, 0);
    check("R4 literal", targets, 8'h30);
    send("R4 cluster0", 8'h03, 1, 0, 0, 0);
    for (int i = 0; i < N; i++) begin fmt[i] = 2'b00; log_id[i] = 8'(1 << i); end
    fmt[2] = 2'b10; fmt[6] = 2'b11;
    send("R5 bad format", 8'hFF, 1, 0, 0, 0);
    check("R5 literal", targets, 8'hBB);
    fmt[2] = 2'b00; fmt[6] = 2'b00;
    send("R1 self", 8'h00, 0, 1, 0, 6);
    check("R1 self literal", targets, 8'h40);
    send("R1 all excl", 8'h00, 0, 3, 0, 0);
    check("R1 excl literal", targets, 8'hFE);

    send("R6 rr first", 8'hFF, 0, 0, 1, 0);
    check("R6 literal", targets, 8'h02);
    send("R6 rr second", 8'hFF, 0, 0, 1, 0);
    check("R6 literal2", targets, 8'h04);
    enabled = 8'b1000_0001;
    send("R6 rr wrap", 8'hFF, 0, 0, 1, 0);
    check("R6 literal3", targets, 8'h80);
    send("R6 rr wrap0", 8'hFF, 0, 0, 1, 0);
    check("R6 literal4", targets, 8'h01);
    enabled = '0;
    send("R7 none", 8'hFF, 0, 0, 1, 0);
    check("R7 literal", targets, 8'h00);
    enabled = '1;
    send("R7 ptr kept", 8'hFF, 0, 0, 1, 0);
    check("R7 literal2", targets, 8'h02);
    enabled = 8'h0F;
    send("R8 enable ignored", 8'hFF, 0, 0, 0, 0);
    check("R8 literal", targets, 8'hFF);
    idle_check();

    for (int n = 0; n < 400; n++) begin
      present = 8'($urandom);
      enabled = 8'($urandom);
      for (int i = 0; i < N; i++) begin
        apic_id[i] = 8'($urandom_range(0, 15));
        log_id[i]  = 8'($urandom);
        fmt[i]     = 2'($urandom);
      end
      send("R1 R2 R3 R4 R5 R6 R7 R8 R9 random", 8'($urandom_range(0, 3) == 0 ? 8'hFF : $urandom),
           1'($urandom), 2'($urandom), 3'($urandom_range(0, 2)), 3'($urandom));
      if (n % 37 == 0) idle_check();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule